// File: doc/BRIEF.md
# Byte-Loaded Test-Clock Cycle Budget Counter

This block holds the number of test-clock cycles that a scan operation may still apply. It is a binary down-counter built from byte lanes. A host on a narrow byte port fills it with four writes to a single address, starting with the least significant byte. The host can read each lane back at its own address. The block combines "never loaded" and "reached zero" into one done condition. That condition is exported for three uses: as a status bit, to stop the test clock, and gated by an enable bit as an interrupt request.

An external clock-gating stage pulses `tck_tick` once for each test-clock cycle it generates. While counting is enabled, the counter drops by one on each pulse. A self-clearing step command drops the count by one system-clock cycle without any test clock. A separate flag reports a count of exactly one, so that a neighbouring block can force the mode-select line high on the final cycle.

Top module: `tck_budget_counter`

## Requirements
- R1: After reset the count is 0, the counter is not loaded (`cnt_done`=1), the count-enable bit is 1, the interrupt-enable bit is 0, no step is pending and the next load write goes to the lowest lane.
- R2: Four writes to address 3'b100 fill the count least significant byte first. The first write of a sequence clears the loaded state and the fourth sets it. `cnt_done` stays 1 until the fourth write.
- R3: Reads return count bits 7:0 at 3'b100, bits 15:8 at 3'b000, bits 23:16 at 3'b010 and bits 31:24 at 3'b011, combinationally from the address.
- R4: When loaded and nonzero, the count drops by one on each rising edge with `tck_tick`=1 while the count-enable bit (bit 5, address 3'b101) is 1. It is unchanged when the enable bit is 0.
- R5: Zero is the terminal count: the counter holds at 0. `cnt_done` = not loaded OR count==0, and it reads back as bit 5 at address 3'b111.
- R6: `tck_hold` is 1 exactly when the count-enable bit is 1 and `cnt_done` is 1.
- R7: `irq_req` is 1 exactly when the interrupt-enable bit (bit 5, address 3'b110) is 1 and `cnt_done` is 1.
- R8: Writing bit 0 = 1 at address 3'b111 sets a step flag, which reads back as bit 0 there. On the next edge the loaded count drops by one whatever the enable bit holds, and the flag clears. A tick in the same cycle still gives only one decrement.
- R9: `cnt_at_one` is 1 exactly when the count equals 1.
- R10: Writes to addresses 3'b000 to 3'b011 have no effect. A load write takes priority over any decrement in the same cycle. Unused bits read as 0, and addresses 3'b001 and 3'b101/3'b110 read back only the bits defined above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_stb | input | 1 | One-cycle access strobe |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | LANE_W | Write data |
| bus_rdata | output | LANE_W | Read data, decoded from `bus_addr` |
| tck_tick | input | 1 | One pulse per generated test-clock cycle |
| cnt_done | output | 1 | Not loaded or at zero |
| tck_hold | output | 1 | Stop request for the test clock |
| irq_req | output | 1 | Interrupt request |
| cnt_at_one | output | 1 | Count equals one |

## Verification
Every output is a combinational function of registers. A write or tick that is present at rising edge k therefore shows up just after edge k. The one exception is a step command: its write at edge k sets the pending flag, and the decrement follows at edge k+1. The bench drives each stimulus at the falling edge, compares all outputs and the addressed read data 1 ns later against a reference model, and advances that model at the rising edge. Each comparison thus lands in the cycle where the requirement says the result is due.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
   localparam int unsigned LANES = 4;
   typedef logic [2:0] addr_t;

   localparam addr_t A_LOAD  = 3'b100;
   localparam addr_t A_CTRL0 = 3'b101;
   localparam addr_t A_CTRL1 = 3'b110;
   localparam addr_t A_CMD   = 3'b111;

   localparam int unsigned BIT_EN   = 5;
   localparam int unsigned BIT_IE   = 5;
   localparam int unsigned BIT_DONE = 5;
   localparam int unsigned BIT_STEP = 0;

   function automatic addr_t lane_rd_addr(input int unsigned lane);
      case (lane)
         0:       return 3'b100;
         1:       return 3'b000;
         2:       return 3'b010;
         3:       return 3'b011;
         default: return 3'b001;
      endcase
   endfunction
endpackage

// File: rtl/tbc_load_seq.sv
module tbc_load_seq #(
   parameter int unsigned LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_wr,
   output logic [LANES-1:0] lane_we,
   output logic             loaded
);
   localparam int unsigned PTR_W = (LANES > 1) ? $clog2(LANES) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(LANES - 1);

   logic [PTR_W-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         loaded <= 1'b0;
      end else if (load_wr) begin
         if (ptr_q == LAST) begin
            ptr_q  <= '0;
            loaded <= 1'b1;
         end else begin
            if (ptr_q == '0) loaded <= 1'b0;
            ptr_q <= ptr_q + 1'b1;
         end
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_we
      assign lane_we[i] = load_wr && (ptr_q == PTR_W'(i));
   end
endmodule

// File: rtl/tbc_count.sv
module tbc_count #(
   parameter  int unsigned LANE_W = 8,
   parameter  int unsigned LANES  = 4,
   localparam int unsigned CNT_W  = LANE_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LANES-1:0]  lane_we,
   input  logic [LANE_W-1:0] wdata,
   input  logic              dec,
   output logic [CNT_W-1:0]  count,
   output logic              is_zero,
   output logic              is_one
);
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] count_m1;

   assign count_m1 = count_q - CNT_W'(1);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            count_q[i*LANE_W +: LANE_W] <= '0;
         else if (lane_we[i])
            count_q[i*LANE_W +: LANE_W] <= wdata;
         else if (dec)
            count_q[i*LANE_W +: LANE_W] <= count_m1[i*LANE_W +: LANE_W];
      end
   end

   assign count   = count_q;
   assign is_zero = (count_q == '0);
   assign is_one  = (count_q == CNT_W'(1));
endmodule

// File: rtl/tbc_ctrl.sv
module tbc_ctrl
   import tbc_pkg::*;
#(
   parameter int unsigned LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  addr_t             addr,
   input  logic [LANE_W-1:0] wdata,
   output logic              load_wr,
   output logic              cmd_wr,
   output logic              cnt_en,
   output logic              irq_en,
   output logic              step_pend
);
   assign load_wr = wr && (addr == A_LOAD);
   assign cmd_wr  = wr && (addr == A_CMD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_en    <= 1'b1;
         irq_en    <= 1'b0;
         step_pend <= 1'b0;
      end else begin
         if (wr && (addr == A_CTRL0)) cnt_en <= wdata[BIT_EN];
         if (wr && (addr == A_CTRL1)) irq_en <= wdata[BIT_IE];
         step_pend <= cmd_wr && wdata[BIT_STEP];
      end
   end
endmodule

// File: rtl/tbc_rdmux.sv
module tbc_rdmux
   import tbc_pkg::*;
#(
   parameter  int unsigned LANE_W = 8,
   localparam int unsigned CNT_W  = LANE_W * LANES
) (
   input  addr_t             addr,
   input  logic [CNT_W-1:0]  count,
   input  logic              cnt_en,
   input  logic              irq_en,
   input  logic              done,
   input  logic              step_pend,
   output logic [LANE_W-1:0] rdata
);
   always_comb begin
      rdata = '0;
      for (int unsigned i = 0; i < LANES; i++) begin
         if (addr == lane_rd_addr(i)) rdata = count[i*LANE_W +: LANE_W];
      end
      case (addr)
         A_CTRL0: rdata[BIT_EN] = cnt_en;
         A_CTRL1: rdata[BIT_IE] = irq_en;
         A_CMD: begin
            rdata[BIT_DONE] = done;
            rdata[BIT_STEP] = step_pend;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/tck_budget_counter.sv
module tck_budget_counter
   import tbc_pkg::*;
#(
   parameter int unsigned LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_stb,
   input  logic              bus_rnw,
   input  logic [2:0]        bus_addr,
   input  logic [LANE_W-1:0] bus_wdata,
   output logic [LANE_W-1:0] bus_rdata,
   input  logic              tck_tick,
   output logic              cnt_done,
   output logic              tck_hold,
   output logic              irq_req,
   output logic              cnt_at_one
);
   localparam int unsigned CNT_W = LANE_W * LANES;

   if (LANE_W < BIT_DONE + 1) begin : g_bad_lane_w
      $error("LANE_W must hold the status bit positions");
   end
   if (LANE_W > 16) begin : g_big_lane_w
      $error("LANE_W above 16 is not supported");
   end

   logic             wr;
   logic             load_wr;
   logic             cmd_wr;
   logic             cnt_en;
   logic             irq_en;
   logic             step_pend;
   logic [LANES-1:0] lane_we;
   logic             loaded;
   logic [CNT_W-1:0] count_q;
   logic             cnt_zero;
   logic             cnt_one;
   logic             dec;

   assign wr = bus_stb && !bus_rnw;

   tbc_ctrl #(.LANE_W(LANE_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .load_wr   (load_wr),
      .cmd_wr    (cmd_wr),
      .cnt_en    (cnt_en),
      .irq_en    (irq_en),
      .step_pend (step_pend)
   );

   tbc_load_seq #(.LANES(LANES)) u_load (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_wr (load_wr),
      .lane_we (lane_we),
      .loaded  (loaded)
   );

   assign dec = loaded && !cnt_zero && !load_wr &&
                ((tck_tick && cnt_en) || step_pend);

   tbc_count #(.LANE_W(LANE_W), .LANES(LANES)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .lane_we (lane_we),
      .wdata   (bus_wdata),
      .dec     (dec),
      .count   (count_q),
      .is_zero (cnt_zero),
      .is_one  (cnt_one)
   );

   assign cnt_done   = !loaded || cnt_zero;
   assign tck_hold   = cnt_en && cnt_done;
   assign irq_req    = irq_en && cnt_done;
   assign cnt_at_one = cnt_one;

   tbc_rdmux #(.LANE_W(LANE_W)) u_rd (
      .addr      (bus_addr),
      .count     (count_q),
      .cnt_en    (cnt_en),
      .irq_en    (irq_en),
      .done      (cnt_done),
      .step_pend (step_pend),
      .rdata     (bus_rdata)
   );
endmodule

// File: rtl/tbc_chk.sv
module tbc_chk #(
   parameter int unsigned CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count,
   input logic             loaded,
   input logic             load_wr,
   input logic             cmd_wr,
   input logic             step_pend,
   input logic             cnt_en,
   input logic             tck_tick,
   input logic             cnt_done,
   input logic             irq_req,
   input logic             cnt_at_one
);
   AST_HOLD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && !load_wr) |=> (count == '0)); // R5

   AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (loaded && count != '0 && !load_wr && ((tck_tick && cnt_en) || step_pend))
      |=> (count == $past(count) - CNT_W'(1))); // R4

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_wr && !(tck_tick && cnt_en) && !step_pend) |=> $stable(count)); // R4

   AST_STEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (step_pend && !cmd_wr) |=> !step_pend); // R8

   AST_LOADED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loaded) |-> $past(load_wr)); // R2

   AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> cnt_done); // R7

   AST_ONE_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_at_one && loaded && tck_tick && cnt_en && !load_wr) |=> cnt_done); // R9
endmodule

bind tck_budget_counter tbc_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .count      (count_q),
   .loaded     (loaded),
   .load_wr    (load_wr),
   .cmd_wr     (cmd_wr),
   .step_pend  (step_pend),
   .cnt_en     (cnt_en),
   .tck_tick   (tck_tick),
   .cnt_done   (cnt_done),
   .irq_req    (irq_req),
   .cnt_at_one (cnt_at_one)
);

// File: tb/tck_budget_counter_tb.sv
`timescale 1ns/1ps
module tck_budget_counter_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       bus_stb, bus_rnw, tck_tick;
   logic [2:0] bus_addr;
   logic [7:0] bus_wdata, bus_rdata;
   logic       cnt_done, tck_hold, irq_req, cnt_at_one;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [31:0] m_cnt;
   logic        m_loaded, m_en, m_ie, m_step;
   int          m_ptr;

   always #5 clk = ~clk;

   tck_budget_counter #(.LANE_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_stb(bus_stb), .bus_rnw(bus_rnw),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tck_tick(tck_tick), .cnt_done(cnt_done), .tck_hold(tck_hold),
      .irq_req(irq_req), .cnt_at_one(cnt_at_one)
   );

   function automatic logic m_done();
      return !m_loaded || (m_cnt == 32'd0);
   endfunction

   function automatic logic [7:0] model_rd(input logic [2:0] a);
      case (a)
         3'b100:  return m_cnt[7:0];
         3'b000:  return m_cnt[15:8];
         3'b010:  return m_cnt[23:16];
         3'b011:  return m_cnt[31:24];
         3'b101:  return {2'b00, m_en, 5'b0};
         3'b110:  return {2'b00, m_ie, 5'b0};
         3'b111:  return {2'b00, m_done(), 4'b0, m_step};
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_cnt = 0; m_loaded = 0; m_ptr = 0; m_en = 1; m_ie = 0; m_step = 0;
   endtask

   task automatic cyc(input logic stb, input logic rnw, input logic [2:0] a,
                      input logic [7:0] wd, input logic tk, input string rtag);
      logic wr, en_o, step_o;
      @(negedge clk);
      bus_stb = stb; bus_rnw = rnw; bus_addr = a; bus_wdata = wd; tck_tick = tk;
      #1;
      check({24'd0, bus_rdata}, {24'd0, model_rd(a)}, rtag);
      check({31'd0, cnt_done}, {31'd0, m_done()}, "R5");
      check({31'd0, tck_hold}, {31'd0, m_en && m_done()}, "R6");
      check({31'd0, irq_req}, {31'd0, m_ie && m_done()}, "R7");
      check({31'd0, cnt_at_one}, {31'd0, m_cnt == 32'd1}, "R9");
      @(posedge clk);
      wr = stb && !rnw; en_o = m_en; step_o = m_step;
      if (wr && a == 3'b100) begin
         if (m_ptr == 0) m_loaded = 0;
         m_cnt[m_ptr*8 +: 8] = wd;
         if (m_ptr == 3) begin m_ptr = 0; m_loaded = 1; end
         else m_ptr++;
      end else if (m_loaded && m_cnt != 0 && ((tk && en_o) || step_o)) begin
         m_cnt = m_cnt - 1;
      end
      if (wr && a == 3'b101) m_en = wd[5];
      if (wr && a == 3'b110) m_ie = wd[5];
      m_step = wr && a == 3'b111 && wd[0];
   endtask

   task automatic load32(input logic [31:0] v);
      for (int i = 0; i < 4; i++) cyc(1, 0, 3'b100, v[i*8 +: 8], 0, "R2");
   endtask

   initial begin
      #(200_000 * 10);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] seed_v;
      seed_v = $urandom(32'h1f2e3d4c);
      rst_n = 0; bus_stb = 0; bus_rnw = 1; bus_addr = 0; bus_wdata = 0; tck_tick = 0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      #1;
      // R1: reset state seen at the ports
      check({31'd0, cnt_done}, 32'd1, "R1");
      check({31'd0, tck_hold}, 32'd1, "R1");
      check({31'd0, irq_req}, 32'd0, "R1");
      cyc(1, 1, 3'b101, 0, 0, "R1");
      cyc(1, 1, 3'b110, 0, 0, "R1");
      cyc(1, 1, 3'b111, 0, 0, "R1");
      cyc(1, 1, 3'b100, 0, 1, "R1");

      // R2: three writes keep done high, fourth clears it
      cyc(1, 0, 3'b100, 8'h03, 0, "R2");
      cyc(1, 0, 3'b100, 8'h00, 0, "R2");
      cyc(1, 0, 3'b100, 8'h00, 0, "R2");
      #1 check({31'd0, cnt_done}, 32'd1, "R2");
      cyc(1, 0, 3'b100, 8'h00, 0, "R2");
      #1 check({31'd0, cnt_done}, 32'd0, "R2");

      // R4/R5: count down to zero then hold
      for (int i = 0; i < 5; i++) cyc(0, 1, 3'b100, 0, 1, "R4");
      cyc(1, 1, 3'b111, 0, 1, "R5");

      // R3: lane ordering
      load32(32'h01020304);
      cyc(1, 1, 3'b100, 0, 0, "R3");
      cyc(1, 1, 3'b000, 0, 0, "R3");
      cyc(1, 1, 3'b010, 0, 0, "R3");
      cyc(1, 1, 3'b011, 0, 0, "R3");

      // R10: writes to lane read addresses ignored; load beats tick
      cyc(1, 0, 3'b000, 8'hff, 0, "R10");
      cyc(1, 0, 3'b011, 8'hff, 0, "R10");
      cyc(1, 1, 3'b000, 0, 0, "R10");
      cyc(1, 1, 3'b001, 0, 0, "R10");
      cyc(1, 0, 3'b100, 8'h02, 1, "R10");
      cyc(1, 1, 3'b100, 0, 1, "R10");

      // R4 disabled, R8 single step, R7 interrupt
      load32(32'h00000002);
      cyc(1, 0, 3'b101, 8'h00, 0, "R4");
      cyc(0, 1, 3'b100, 0, 1, "R4");
      cyc(1, 0, 3'b111, 8'h01, 1, "R8");
      cyc(1, 1, 3'b111, 0, 1, "R8");
      cyc(1, 1, 3'b100, 0, 0, "R8");
      cyc(1, 0, 3'b110, 8'h20, 0, "R7");
      cyc(1, 0, 3'b101, 8'h20, 0, "R4");
      cyc(1, 0, 3'b111, 8'h01, 1, "R8");
      cyc(1, 1, 3'b111, 0, 0, "R8");
      cyc(1, 1, 3'b100, 0, 0, "R9");

      // constrained random mix
      for (int n = 0; n < 4000; n++) begin
         logic [2:0] a;
         logic [7:0] d;
         a = ($urandom % 3 == 0) ? 3'b100 : 3'($urandom);
         d = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 3);
         if (a == 3'b101 || a == 3'b110) d[5] = ($urandom % 4) != 0;
         cyc(1'($urandom), 1'($urandom), a, d, 1'($urandom), "R3");
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule